// File: doc/BRIEF.md
# Interrupt-Terminated Long Write Controller

This block runs a write into on-chip non-volatile program memory for a processor core. A write request arrives with an address and data. If programming voltage is present, the block starts a long write. It holds the CPU stalled and keeps the memory write strobe asserted. The long write has no timer of its own. It ends only when an interrupt source that has both its enable and its flag set is seen, or when a reset occurs. Software therefore sets the programming time by arranging for one enabled interrupt to fire after the required interval.

When the write ends, the block decides two things from the class of the winning source and the global interrupt-disable bit. It decides whether to ask the core to branch to the interrupt vector, and whether to pulse a clear for one of the three core interrupt flags. The peripheral source is never cleared by the block.

Two other outcomes are possible. If programming voltage is missing, the request becomes a two-cycle stall with no strobe, so memory is left unchanged. If a qualifying core interrupt is already pending when the request arrives, the write is dropped as a no-operation and only the winning flag is cleared. A length register reports how many cycles the last long write held the strobe.

Top module: `lwc_top`

## Requirements
- R1: `mem_we` is asserted only while `cpu_stall` is asserted.
- R2: A request with `vpp_ok`=1 and no pending core source sets `cpu_stall` and `mem_we` from the next clock edge. Both stay set until a source with its enable and flag both 1 is sampled. A flag whose enable is 0 has no effect.
- R3: A request with `vpp_ok`=0 holds `cpu_stall` for exactly 2 cycles, never asserts `mem_we`, and raises no `vec_req`.
- R4: A long write ended by a core source with `glb_dis`=0 stops the stall. In the next cycle it gives a one-cycle `vec_req` pulse and a one-cycle `core_flag_clr` pulse on the winning bit.
- R5: A long write ended by a core source with `glb_dis`=1 also ends the write and pulses `core_flag_clr` on the winning bit, but gives no `vec_req`.
- R6: A long write ended by the peripheral source pulses `vec_req` exactly when `glb_dis`=0 and never pulses any `core_flag_clr` bit.
- R7: Core priority is bit 0 (external pin) over bit 1 (timer overflow) over bit 2 (timer clock input). Every core source ranks above the peripheral source, and `core_flag_clr` has at most one bit set.
- R8: A request arriving while a core source is enabled and flagged causes no stall and no strobe. The next cycle pulses `wr_abort` and the winning `core_flag_clr` bit, with no `vec_req`.
- R9: With `rst`=1 at a clock edge, `cpu_stall`, `mem_we`, `vec_req` and `last_len` are 0 after that edge, whatever the state.
- R10: `last_len` is updated at the end of each long write to the number of cycles `mem_we` was high. It is left unchanged by short and aborted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Table write request, sampled in idle |
| wr_addr | input | ADDR_W | Target program memory address |
| wr_data | input | DATA_W | Word to program |
| vpp_ok | input | 1 | Programming voltage present |
| core_en | input | N_CORE | Core source enables (bit 0 highest priority) |
| core_flag | input | N_CORE | Core source flags |
| per_en | input | 1 | Peripheral source enable |
| per_flag | input | 1 | Peripheral source flag |
| glb_dis | input | 1 | Global disable: blocks vectoring only |
| cpu_stall | output | 1 | Halts instruction execution |
| mem_we | output | 1 | Program memory write strobe |
| mem_addr | output | ADDR_W | Latched write address |
| mem_data | output | DATA_W | Latched write data |
| core_flag_clr | output | N_CORE | One-cycle clear pulse for a core flag |
| vec_req | output | 1 | One-cycle request to branch to the interrupt vector |
| wr_abort | output | 1 | One-cycle pulse: request dropped as no-operation |
| last_len | output | LEN_W | Strobe cycles of the last long write |

## Verification
The bench ends long writes from each source class with `glb_dis` both clear and set. A design that confused the two classes would clear the peripheral flag or miss the core clear. A design that let the disable bit block termination would hang in a stall. It keeps enable-less flags raised throughout long writes and raises several sources at once. A design that honoured a bare flag would end the write early, which shows in `last_len`, and a wrong priority encoder would pulse the wrong clear bit. It also covers a missing programming voltage, a request with a core interrupt already pending, and a reset in the middle of a write. These catch a strobe on an unpowered write, a write that starts despite a pending source, and a stray vector request after reset.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHORT = 2'd1,
    ST_LONG  = 2'd2,
    ST_DONE  = 2'd3
  } lw_state_e;
endpackage

// File: rtl/lwc_arbiter.sv
// Qualifies interrupt sources (enable AND flag) and picks the core winner.
module lwc_arbiter #(
  parameter int N_CORE = 3
) (
  input  logic [N_CORE-1:0] core_en,
  input  logic [N_CORE-1:0] core_flag,
  input  logic              per_en,
  input  logic              per_flag,
  output logic [N_CORE-1:0] core_win,
  output logic              core_hit,
  output logic              any_hit
);
  logic [N_CORE-1:0] pend;
  logic [N_CORE:0]   seen;

  assign pend = core_en & core_flag;

  // lowest index wins: ripple a "higher one already found" chain
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N_CORE; i++) begin : g_pri
    assign core_win[i] = pend[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | pend[i];
  end

  assign core_hit = seen[N_CORE];
  assign any_hit  = core_hit | (per_en & per_flag);
endmodule

// File: rtl/lwc_len_counter.sv
// Counts strobe cycles of a long write and captures the total at its end.
module lwc_len_counter #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic             capture,
  output logic [LEN_W-1:0] last_len
);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      last_len <= '0;
    end else begin
      if (start) begin
        cnt <= LEN_W'(1);
      end else if (run && !capture && cnt != LEN_MAX) begin
        cnt <= cnt + LEN_W'(1);
      end
      if (capture) begin
        last_len <= cnt;
      end
    end
  end
endmodule

// File: rtl/lwc_fsm.sv
// Sequencer: idle / short write / long write / done, all outputs registered.
module lwc_fsm
  import lwc_pkg::*;
#(
  parameter int N_CORE    = 3,
  parameter int SHORT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              vpp_ok,
  input  logic              glb_dis,
  input  logic [N_CORE-1:0] core_win,
  input  logic              core_hit,
  input  logic              any_hit,
  output logic              start,
  output logic              run,
  output logic              capture,
  output logic              cpu_stall,
  output logic              mem_we,
  output logic [N_CORE-1:0] core_flag_clr,
  output logic              vec_req,
  output logic              wr_abort
);
  localparam int SC_W = (SHORT_CYC > 1) ? $clog2(SHORT_CYC) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SHORT_CYC - 1);

  lw_state_e       state;
  logic [SC_W-1:0] sc;

  assign start   = (state == ST_IDLE) && wr_req && !core_hit && vpp_ok;
  assign run     = (state == ST_LONG);
  assign capture = (state == ST_LONG) && any_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      sc            <= '0;
      cpu_stall     <= 1'b0;
      mem_we        <= 1'b0;
      core_flag_clr <= '0;
      vec_req       <= 1'b0;
      wr_abort      <= 1'b0;
    end else begin
      core_flag_clr <= '0;
      vec_req       <= 1'b0;
      wr_abort      <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (wr_req) begin
            if (core_hit) begin
              state         <= ST_DONE;
              wr_abort      <= 1'b1;
              core_flag_clr <= core_win;
            end else if (!vpp_ok) begin
              state     <= ST_SHORT;
              sc        <= '0;
              cpu_stall <= 1'b1;
            end else begin
              state     <= ST_LONG;
              cpu_stall <= 1'b1;
              mem_we    <= 1'b1;
            end
          end
        end
        ST_SHORT: begin
          if (sc == SC_LAST) begin
            state     <= ST_IDLE;
            cpu_stall <= 1'b0;
          end else begin
            sc <= sc + SC_W'(1);
          end
        end
        ST_LONG: begin
          if (any_hit) begin
            state         <= ST_DONE;
            cpu_stall     <= 1'b0;
            mem_we        <= 1'b0;
            core_flag_clr <= core_win;
            vec_req       <= !glb_dis;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lwc_top.sv
module lwc_top #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int N_CORE    = 3,
  parameter int LEN_W     = 24,
  parameter int SHORT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vpp_ok,
  input  logic [N_CORE-1:0] core_en,
  input  logic [N_CORE-1:0] core_flag,
  input  logic              per_en,
  input  logic              per_flag,
  input  logic              glb_dis,
  output logic              cpu_stall,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [N_CORE-1:0] core_flag_clr,
  output logic              vec_req,
  output logic              wr_abort,
  output logic [LEN_W-1:0]  last_len
);
  logic [N_CORE-1:0] core_win;
  logic core_hit, any_hit, start, run, capture;

  lwc_arbiter #(.N_CORE(N_CORE)) u_arb (
    .core_en(core_en), .core_flag(core_flag),
    .per_en(per_en), .per_flag(per_flag),
    .core_win(core_win), .core_hit(core_hit), .any_hit(any_hit)
  );

  lwc_fsm #(.N_CORE(N_CORE), .SHORT_CYC(SHORT_CYC)) u_fsm (
    .clk(clk), .rst(rst), .wr_req(wr_req), .vpp_ok(vpp_ok),
    .glb_dis(glb_dis), .core_win(core_win), .core_hit(core_hit),
    .any_hit(any_hit), .start(start), .run(run), .capture(capture),
    .cpu_stall(cpu_stall), .mem_we(mem_we), .core_flag_clr(core_flag_clr),
    .vec_req(vec_req), .wr_abort(wr_abort)
  );

  lwc_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .start(start), .run(run),
    .capture(capture), .last_len(last_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_data <= '0;
    end else if (start) begin
      mem_addr <= wr_addr;
      mem_data <= wr_data;
    end
  end
endmodule

// File: rtl/lwc_checker.sv
module lwc_checker #(
  parameter int N_CORE = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [N_CORE-1:0] core_en,
  input logic [N_CORE-1:0] core_flag,
  input logic              per_en,
  input logic              per_flag,
  input logic              glb_dis,
  input logic              cpu_stall,
  input logic              mem_we,
  input logic [N_CORE-1:0] core_flag_clr,
  input logic              vec_req,
  input logic              wr_abort
);
  assert_we_in_stall_R1: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> cpu_stall);

  assert_hold_until_hit_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_we && ((core_en & core_flag) == '0) && !(per_en && per_flag)) |=> mem_we);

  assert_vec_gated_R4: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> ($past(mem_we) && !$past(glb_dis)));

  assert_clr_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_flag_clr));

  assert_abort_shape_R8: assert property (@(posedge clk) disable iff (rst)
    wr_abort |-> (!vec_req && !cpu_stall && $onehot(core_flag_clr)));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (!cpu_stall && !mem_we && !vec_req));
endmodule

bind lwc_top lwc_checker #(.N_CORE(N_CORE)) u_chk (
  .clk(clk), .rst(rst), .core_en(core_en), .core_flag(core_flag),
  .per_en(per_en), .per_flag(per_flag), .glb_dis(glb_dis),
  .cpu_stall(cpu_stall), .mem_we(mem_we), .core_flag_clr(core_flag_clr),
  .vec_req(vec_req), .wr_abort(wr_abort)
);

// File: tb/lwc_top_bench.sv
`timescale 1ns/1ps
module lwc_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_req = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0;
  logic vpp_ok = 1'b1;
  logic [2:0] core_en = '0, core_flag = '0;
  logic per_en = 1'b0, per_flag = 1'b0, glb_dis = 1'b0;
  logic cpu_stall, mem_we, vec_req, wr_abort;
  logic [15:0] mem_addr, mem_data;
  logic [2:0] core_flag_clr;
  logic [23:0] last_len;

  always #4 clk = ~clk;

  lwc_top u_lwc_top (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_ok(vpp_ok), .core_en(core_en), .core_flag(core_flag), .per_en(per_en),
    .per_flag(per_flag), .glb_dis(glb_dis), .cpu_stall(cpu_stall), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_data(mem_data), .core_flag_clr(core_flag_clr),
    .vec_req(vec_req), .wr_abort(wr_abort), .last_len(last_len)
  );

  typedef struct {
    string    tag;
    int       stall_cyc;
    int       we_cyc;
    logic     vec;
    logic [2:0] clr;
    logic     abort;
    int       len;
  } exp_t;

  exp_t exp_q[$];
  int total = 0, bad = 0;
  int model_len = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  // monitor: pops an expected item at every end-of-operation event
  int  st_cyc = 0, we_cyc = 0;
  bit  prev_stall = 0;
  always @(negedge clk) begin
    if (rst) begin
      st_cyc = 0; we_cyc = 0; prev_stall = 0;
    end else begin
      if (cpu_stall) st_cyc++;
      if (mem_we) we_cyc++;
      if ((prev_stall && !cpu_stall) || wr_abort) begin
        if (exp_q.size() == 0) begin
          chk(0, "R1", "unexpected end event", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(st_cyc == e.stall_cyc, e.tag, "stall cycles", st_cyc, e.stall_cyc);
          chk(we_cyc == e.we_cyc, e.tag, "strobe cycles", we_cyc, e.we_cyc);
          chk(vec_req == e.vec, e.tag, "vec_req", int'(vec_req), int'(e.vec));
          chk(core_flag_clr == e.clr, e.tag, "core_flag_clr",
              int'(core_flag_clr), int'(e.clr));
          chk(wr_abort == e.abort, e.tag, "wr_abort", int'(wr_abort), int'(e.abort));
          chk(int'(last_len) == e.len, e.tag, "last_len", int'(last_len), e.len);
        end
        st_cyc = 0; we_cyc = 0;
      end else if (vec_req || core_flag_clr != '0) begin
        chk(0, "R4", "stray pulse outside end event", 1, 0);
      end
      prev_stall = cpu_stall;
    end
  end

  // long write lasting n strobe cycles, then the given sources fire
  task automatic long_write(input string tag, input int n, input logic [2:0] ce,
                            input logic [2:0] cf, input logic pe, input logic pf,
                            input logic gd, input logic ev, input logic [2:0] ec);
    exp_t e;
    @(negedge clk);
    vpp_ok = 1; glb_dis = gd;
    core_en = '0; core_flag = ~ce;      // R2: flags without enable, ignored
    per_en = 0; per_flag = !pe;
    wr_addr = 16'h100 + 16'(n); wr_data = 16'hA500 + 16'(n);
    wr_req = 1;
    model_len = n;
    e = '{tag, n, n, ev, ec, 1'b0, n};
    exp_q.push_back(e);
    @(negedge clk);
    wr_req = 0;
    chk(mem_addr == 16'h100 + 16'(n), "R2", "latched address",
        int'(mem_addr), 32'h100 + n);
    repeat (n - 1) @(negedge clk);
    core_en = ce; core_flag = cf | ~ce;
    per_en = pe; per_flag = pf | !pe;
    @(negedge clk);
    core_en = '0; core_flag = '0; per_en = 0; per_flag = 0;
  endtask

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!cpu_stall && !mem_we && !vec_req && last_len == 0, "R9", "reset outputs",
        int'(cpu_stall) + int'(mem_we) + int'(vec_req), 0);
    rst = 0;

    long_write("R4", 5, 3'b010, 3'b010, 0, 0, 0, 1, 3'b010);
    long_write("R5", 3, 3'b100, 3'b100, 0, 0, 1, 0, 3'b100);
    long_write("R6", 4, 3'b000, 3'b000, 1, 1, 0, 1, 3'b000);
    long_write("R6", 2, 3'b000, 3'b000, 1, 1, 1, 0, 3'b000);
    long_write("R7", 6, 3'b111, 3'b111, 1, 1, 0, 1, 3'b001);
    long_write("R7", 3, 3'b110, 3'b110, 1, 1, 1, 0, 3'b010);

    // R3 and R10: no programming voltage, short stall, length unchanged
    @(negedge clk);
    vpp_ok = 0; wr_req = 1;
    e = '{"R3", 2, 0, 1'b0, 3'b000, 1'b0, model_len};
    exp_q.push_back(e);
    @(negedge clk); wr_req = 0;
    repeat (3) @(negedge clk);
    vpp_ok = 1;

    // R8: core source pending at request time
    @(negedge clk);
    core_en = 3'b110; core_flag = 3'b111; wr_req = 1;
    e = '{"R8", 0, 0, 1'b0, 3'b010, 1'b1, model_len};
    exp_q.push_back(e);
    @(negedge clk);
    wr_req = 0; core_en = '0; core_flag = '0;
    repeat (2) @(negedge clk);

    // R9: reset in the middle of a long write
    wr_req = 1;
    @(negedge clk); wr_req = 0;
    chk(mem_we == 1, "R2", "strobe running before reset", int'(mem_we), 1);
    repeat (2) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(!cpu_stall && !mem_we && !vec_req, "R9", "stall/strobe/vec after reset",
        int'(cpu_stall) + int'(mem_we) + int'(vec_req), 0);
    chk(last_len == 0, "R9", "last_len after reset", int'(last_len), 0);
    rst = 0;
    repeat (2) @(negedge clk);

    // R10: shortest long write after reset
    long_write("R10", 1, 3'b001, 3'b001, 0, 0, 0, 1, 3'b001);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "pending expected items", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule